// File: doc/BRIEF.md
# ADC Window Monitor Comparator

This block watches the stream of conversion results coming out of an analog-to-digital converter and decides, for each result, whether it falls in a region of interest. The region is given by a lower and an upper threshold and by a 3-bit mode. The mode picks one of four strict-inequality tests, or turns the monitor off. A differential flag selects how the numbers are read: as two's-complement signed values when it is set, and as unsigned values when it is clear.

A match is reported in three forms. The first is a combinational signal that is valid in the same cycle as the result strobe. The second is a sticky flag that stays set until software-side logic pulses a clear input. The third is a one-cycle event pulse, meant to feed an interrupt controller.

Top module: `adc_window_monitor`

## Requirements
- R1: With mode 0 (monitor off), `match_o` is never asserted.
- R2: With mode 1, a valid result matches when it is strictly greater than `thr_lo_i`. Equality does not match.
- R3: With mode 2, a valid result matches when it is strictly less than `thr_hi_i`. Equality does not match.
- R4: With mode 3, a valid result matches when `thr_lo_i < result < thr_hi_i`, with both bounds excluded.
- R5: With mode 4, a valid result matches when `thr_hi_i < result < thr_lo_i`, with both bounds excluded.
- R6: Modes 5, 6 and 7 behave like mode 0: no match is ever asserted.
- R7: When `diff_i` is 1, the result and both thresholds are compared as two's-complement signed values. When `diff_i` is 0, they are compared as unsigned values.
- R8: `match_o` is asserted only in a cycle where `res_vld_i` is 1. A result presented without the strobe does not change `evt_o` or `flag_o`.
- R9: `evt_o` is 1 in the cycle after each cycle in which `match_o` was 1, and 0 otherwise.
- R10: `flag_o` becomes 1 in the cycle after a match and stays 1 until `clr_i` is sampled without a match. When a clear and a match arrive in the same cycle, the set wins.
- R11: While reset is active, and until the first valid match after reset, `evt_o` and `flag_o` are 0. Reset is asserted asynchronously and released two clock cycles after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_i | input | DATA_W | Conversion result |
| res_vld_i | input | 1 | Result-valid strobe |
| thr_lo_i | input | DATA_W | Lower threshold |
| thr_hi_i | input | DATA_W | Upper threshold |
| mode_i | input | 3 | Comparison mode, 0 to 7 |
| diff_i | input | 1 | 1 = signed comparison, 0 = unsigned comparison |
| clr_i | input | 1 | Clears the sticky flag |
| match_o | output | 1 | Combinational match for the current result |
| flag_o | output | 1 | Sticky match flag |
| evt_o | output | 1 | One-cycle match event |

## Verification
Two situations are hardest to reach from the ports.

The first is a result whose signed and unsigned readings fall on opposite sides of a threshold. The stimulus reaches it by placing results and thresholds that have the top bit set next to small positive thresholds, then repeating the same values with `diff_i` toggled.

The second is a clear that arrives in the very cycle of a new match, together with results that sit exactly on a threshold. The random phase draws results equal to a threshold, or one step away from it, and raises `clr_i` often enough that it coincides with valid matches many times.

// File: rtl/wmon_pkg.sv
package wmon_pkg;
  typedef enum logic [2:0] {
    WM_OFF     = 3'd0,
    WM_ABOVE   = 3'd1,
    WM_BELOW   = 3'd2,
    WM_INSIDE  = 3'd3,
    WM_BETWEEN = 3'd4
  } wmon_mode_e;
endpackage

// File: rtl/wmon_rst_sync.sv
module wmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wmon_compare.sv
module wmon_compare #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] res,
  input  logic              vld,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [2:0]        mode,
  input  logic              sgn,
  output logic              hit
);
  import wmon_pkg::*;
  localparam int EXT_W = DATA_W + 1;

  logic signed [EXT_W-1:0] res_x, lo_x, hi_x;
  logic above_lo, below_hi, above_hi, below_lo;
  logic cond;

  // One extra sign bit: zero-extend for unsigned, sign-extend for signed
  assign res_x = {sgn & res[DATA_W-1], res};
  assign lo_x  = {sgn & lo[DATA_W-1],  lo};
  assign hi_x  = {sgn & hi[DATA_W-1],  hi};

  assign above_lo = res_x > lo_x;
  assign below_hi = res_x < hi_x;
  assign above_hi = res_x > hi_x;
  assign below_lo = res_x < lo_x;

  always_comb begin
    case (mode)
      WM_ABOVE:   cond = above_lo;
      WM_BELOW:   cond = below_hi;
      WM_INSIDE:  cond = above_lo & below_hi;
      WM_BETWEEN: cond = above_hi & below_lo;
      default:    cond = 1'b0;
    endcase
  end

  assign hit = vld & cond;

  always_comb begin
    if (mode == 3'd0 || mode > 3'd4)
      AST_RESERVED_QUIET: assert (!hit); // R6
    if (!vld)
      AST_NO_HIT_IDLE: assert (!hit); // R8
  end
endmodule

// File: rtl/wmon_event_reg.sv
module wmon_event_reg (
  input  logic clk,
  input  logic rst_sync_n,
  input  logic hit,
  input  logic clr,
  output logic evt,
  output logic flag
);
  logic evt_q, evt_d;
  logic flag_q, flag_d, flag_en;

  always_comb begin
    evt_d   = hit;
    flag_en = hit | clr;
    flag_d  = hit;            // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign evt  = evt_q;
  assign flag = flag_q;

  AST_EVT_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |=> evt_q); // R9
  AST_NO_EVT_WITHOUT_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |=> !evt_q); // R9
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |=> flag_q); // R10
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_q && !clr) |=> flag_q); // R10
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr && !hit) |=> !flag_q); // R10
endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor #(
  parameter int DATA_W   = 12,
  parameter int RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] res_i,
  input  logic              res_vld_i,
  input  logic [DATA_W-1:0] thr_lo_i,
  input  logic [DATA_W-1:0] thr_hi_i,
  input  logic [2:0]        mode_i,
  input  logic              diff_i,
  input  logic              clr_i,
  output logic              match_o,
  output logic              flag_o,
  output logic              evt_o
);
  logic rst_sync_n;
  logic hit;

  wmon_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  wmon_compare #(.DATA_W(DATA_W)) u_cmp (
    .res(res_i), .vld(res_vld_i), .lo(thr_lo_i), .hi(thr_hi_i),
    .mode(mode_i), .sgn(diff_i), .hit(hit)
  );

  wmon_event_reg u_evt (
    .clk(clk), .rst_sync_n(rst_sync_n), .hit(hit), .clr(clr_i),
    .evt(evt_o), .flag(flag_o)
  );

  assign match_o = hit;

  AST_EVT_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt_o |-> flag_o); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (!evt_o && !flag_o)); // R11
endmodule

// File: tb/adc_window_monitor_tb.sv
module adc_window_monitor_tb;
  localparam int W = 12;
  localparam int MAXV = (1 << W);

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] res, lo, hi;
  logic vld, sgn, clr;
  logic [2:0] mode;
  logic match_o, flag_o, evt_o;

  int total = 0;
  int bad = 0;
  bit exp_evt = 0;
  bit exp_flag = 0;

  always #2 clk = ~clk;

  adc_window_monitor #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .res_i(res), .res_vld_i(vld),
    .thr_lo_i(lo), .thr_hi_i(hi), .mode_i(mode), .diff_i(sgn),
    .clr_i(clr), .match_o(match_o), .flag_o(flag_o), .evt_o(evt_o)
  );

  function automatic int to_int(logic [W-1:0] v, logic s);
    if (s && v[W-1]) return int'(v) - MAXV;
    return int'(v);
  endfunction

  function automatic bit ref_match(logic [W-1:0] r, logic [W-1:0] l, logic [W-1:0] h,
                                   logic [2:0] m, logic s, logic v);
    int ri = to_int(r, s);
    int li = to_int(l, s);
    int hv = to_int(h, s);
    if (!v) return 0;
    case (m)
      3'd1: return ri > li;
      3'd2: return ri < hv;
      3'd3: return (ri > li) && (ri < hv);
      3'd4: return (ri > hv) && (ri < li);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, bit act, bit exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(logic [W-1:0] r, logic v, logic [W-1:0] l, logic [W-1:0] h,
                      logic [2:0] m, logic s, logic c, string tag);
    bit em;
    @(negedge clk);
    chk("R9", evt_o, exp_evt, "evt_o");
    chk("R10", flag_o, exp_flag, "flag_o");
    res = r; vld = v; lo = l; hi = h; mode = m; sgn = s; clr = c;
    #1;
    em = ref_match(r, l, h, m, s, v);
    chk(tag, match_o, em, "match_o");
    exp_evt = em;
    if (em) exp_flag = 1;
    else if (c) exp_flag = 0;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; res = 0; vld = 0; lo = 0; hi = 0; mode = 0; sgn = 0; clr = 0;
    repeat (3) @(negedge clk);
    chk("R11", evt_o, 0, "evt_o in reset");
    chk("R11", flag_o, 0, "flag_o in reset");
    rst_n = 1;
    for (int i = 0; i < 5; i++) step(12'd50, 0, 12'd10, 12'd200, 3'd1, 0, 0, "R11");

    step(12'd100, 1, 12'd10, 12'd200, 3'd0, 0, 0, "R1");
    step(12'd11,  1, 12'd10, 12'd200, 3'd1, 0, 0, "R2");
    step(12'd10,  1, 12'd10, 12'd200, 3'd1, 0, 1, "R2");
    step(12'd199, 1, 12'd10, 12'd200, 3'd2, 0, 0, "R3");
    step(12'd200, 1, 12'd10, 12'd200, 3'd2, 0, 1, "R3");
    step(12'd10,  1, 12'd10, 12'd200, 3'd3, 0, 0, "R4");
    step(12'd11,  1, 12'd10, 12'd200, 3'd3, 0, 0, "R4");
    step(12'd200, 1, 12'd10, 12'd200, 3'd3, 0, 1, "R4");
    step(12'd5,   1, 12'd200, 12'd10, 3'd4, 0, 0, "R5");
    step(12'd100, 1, 12'd200, 12'd10, 3'd4, 0, 0, "R5");
    step(12'd200, 1, 12'd200, 12'd10, 3'd4, 0, 1, "R5");
    step(12'd100, 1, 12'd10, 12'd200, 3'd5, 0, 0, "R6");
    step(12'd100, 1, 12'd10, 12'd200, 3'd6, 0, 0, "R6");
    step(12'd100, 1, 12'd10, 12'd200, 3'd7, 0, 0, "R6");
    step(12'hFF0, 1, 12'h010, 12'h7FF, 3'd1, 0, 1, "R7");
    step(12'hFF0, 1, 12'h010, 12'h7FF, 3'd1, 1, 1, "R7");
    step(12'h005, 1, 12'hF00, 12'h010, 3'd3, 1, 0, "R7");
    step(12'h005, 1, 12'hF00, 12'h010, 3'd3, 0, 1, "R7");
    step(12'd100, 0, 12'd10, 12'd200, 3'd1, 0, 0, "R8");
    step(12'd100, 0, 12'd10, 12'd200, 3'd1, 0, 0, "R8");
    step(12'd100, 1, 12'd10, 12'd200, 3'd1, 0, 0, "R10");
    step(12'd100, 0, 12'd10, 12'd200, 3'd1, 0, 0, "R10");
    step(12'd100, 1, 12'd10, 12'd200, 3'd1, 0, 1, "R10");
    step(12'd100, 0, 12'd10, 12'd200, 3'd1, 0, 1, "R10");
    step(12'd100, 0, 12'd10, 12'd200, 3'd1, 0, 0, "R10");

    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] l, h, r;
      logic [2:0] m;
      logic s;
      string tg;
      l = W'($urandom_range(0, MAXV - 1));
      h = W'($urandom_range(0, MAXV - 1));
      case ($urandom_range(0, 4))
        0: r = l;
        1: r = h;
        2: r = l + W'(1);
        3: r = h - W'(1);
        default: r = W'($urandom_range(0, MAXV - 1));
      endcase
      m = 3'($urandom_range(0, 7));
      s = 1'($urandom_range(0, 1));
      case (m)
        3'd0: tg = "R1";
        3'd1: tg = "R2";
        3'd2: tg = "R3";
        3'd3: tg = "R4";
        3'd4: tg = "R5";
        default: tg = "R6";
      endcase
      if (s) tg = {tg, "/R7"};
      step(r, 1'($urandom_range(0, 3) != 0), l, h, m, s,
           1'($urandom_range(0, 3) == 0), tg);
    end

    @(negedge clk);
    chk("R9", evt_o, exp_evt, "evt_o");
    chk("R10", flag_o, exp_flag, "flag_o");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule